// File: doc/BRIEF.md
# PLL Lock and Track Supervisor

This block watches a phase-locked loop from the digital side. It counts the pulses of the divided oscillator clock over a fixed window of reference clock cycles. It then compares that count with a programmed target count. The absolute difference is the frequency error. Two hysteresis comparators turn the error into two status flags. The track flag decides whether the loop filter works in its wide-band acquisition mode or its narrow-band tracking mode. The lock flag shows that the multiplied clock is safe to use as a system clock source.

Each flag uses a tight tolerance to become set and a wider tolerance to become clear. A small amount of error therefore cannot make a flag chatter. The filter mode can come from the track flag (automatic control) or from a bit that software writes (manual control). Any change of the lock flag can raise a sticky interrupt. Software clears it by writing 1.

The oscillator pulse input must already be a single-cycle enable in the reference clock domain. The analog filter, the oscillator and the clock switch are not part of this block.

Top module: `pll_lock_track_det`

## Requirements
- R1: While reset is active, and on every cycle where `pll_on` is low, the block holds `track` and `lock` at 0 and `filt_acq` at 1 (acquisition). After reset, `irq` is 0.
- R2: With `pll_on` high, each window lasts WIN_LEN reference cycles and counts the cycles in which `osc_tick` is 1. The window counter restarts when `pll_on` rises. The error is |count − `target`|. `track` and `lock` change only on the clock edge that follows the last cycle of a window, and they stay stable for the whole of the next window.
- R3: A clear `track` becomes set at a window end when the error is at most TRK_ENTER.
- R4: A set `track` stays set while the error is at most TRK_EXIT. It clears only when the error exceeds TRK_EXIT. TRK_ENTER must be less than TRK_EXIT.
- R5: A clear `lock` becomes set at a window end when the error is at most LCK_ENTER.
- R6: A set `lock` stays set while the error is at most LCK_EXIT. It clears only when the error exceeds LCK_EXIT. LCK_ENTER must be less than LCK_EXIT.
- R7: With `auto_mode` = 1, `filt_acq` is the inverse of `track`. The filter is in tracking mode (`filt_acq` = 0) exactly when `track` is 1.
- R8: With `auto_mode` = 0 and `pll_on` = 1, `filt_acq` follows `acq_sel` (1 = acquisition, 0 = tracking). `track` is forced to 0 while `acq_sel` is 1. While `acq_sel` is 0, `track` shows the track comparator.
- R9: When `lock_ie` is 1, a change of `lock` in either direction sets `irq` on the same edge as the change. When `lock_ie` is 0, a change of `lock` leaves `irq` unchanged.
- R10: `irq` stays set until a cycle with `irq_clr` = 1 clears it. If a lock change that is enabled happens in the same cycle as the clear, `irq` stays 1.
- R11: `pll_safe` always equals `lock`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pll_on | input | 1 | PLL enable. When low, both flags clear and the window restarts |
| osc_tick | input | 1 | One pulse per divided oscillator cycle, synchronous to clk |
| target | input | CNT_W | Expected oscillator count per window |
| auto_mode | input | 1 | 1 = detector picks the filter mode, 0 = `acq_sel` picks it |
| acq_sel | input | 1 | Manual filter mode select, 1 = acquisition |
| lock_ie | input | 1 | Enables the interrupt on lock changes |
| irq_clr | input | 1 | Write-1 clear of the interrupt flag |
| filt_acq | output | 1 | Filter mode to the loop filter, 1 = acquisition |
| track | output | 1 | Tracking status flag |
| lock | output | 1 | Lock status flag |
| irq | output | 1 | Sticky lock-change interrupt flag |
| pll_safe | output | 1 | PLL clock safe to select (equals `lock`) |

## Verification
The bench steps through windows at errors that sit exactly on each enter and exit tolerance and just beyond it. A design that uses a single threshold, or that confuses < with ≤, gives the wrong flag on one of those rows. The flags are also sampled in the middle of each window, which catches a design that updates before the window ends. In one test a clear and a lock change arrive in the same cycle. A design that gives the clear priority drops the interrupt there. Other tests disable the interrupt, switch the PLL off while locked, and force acquisition in manual mode while the comparator reports good tracking. These catch a design that ignores the enable, keeps stale flags, or lets `track` show through during acquisition.

// File: rtl/pltd_pkg.sv
package pltd_pkg;

   typedef enum logic {
      FILT_TRACK = 1'b0,
      FILT_ACQ   = 1'b1
   } pltd_filt_e;

   function automatic int pltd_cnt_bits(input int max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction

endpackage

// File: rtl/pltd_window.sv
module pltd_window #(
   parameter int WIN_LEN = 32,
   parameter int CNT_W   = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   output logic             done,
   output logic [CNT_W-1:0] count
);
   localparam int WC_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;

   logic             last;
   logic [CNT_W-1:0] acc;

   if (CNT_W < pltd_pkg::pltd_cnt_bits(WIN_LEN)) begin : g_bad_cnt_w
      $error("CNT_W too small for WIN_LEN");
   end

   if (WIN_LEN == 1) begin : g_single
      assign last = 1'b1;
   end else begin : g_multi
      logic [WC_W-1:0] win_cnt;
      assign last = (win_cnt == WC_W'(WIN_LEN - 1));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        win_cnt <= '0;
         else if (!run)     win_cnt <= '0;
         else if (last)     win_cnt <= '0;
         else               win_cnt <= win_cnt + 1'b1;
      end

      // R2
      window_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
         done |=> !done);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc   <= '0;
         count <= '0;
         done  <= 1'b0;
      end else if (!run) begin
         acc   <= '0;
         done  <= 1'b0;
      end else if (last) begin
         count <= acc + CNT_W'(tick);
         acc   <= '0;
         done  <= 1'b1;
      end else begin
         acc   <= acc + CNT_W'(tick);
         done  <= 1'b0;
      end
   end

endmodule

// File: rtl/pltd_hyst.sv
module pltd_hyst #(
   parameter int CNT_W = 6,
   parameter int ENTER = 2,
   parameter int EXIT  = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             upd,
   input  logic [CNT_W-1:0] err,
   output logic             state,
   output logic             toggle
);
   localparam logic [CNT_W-1:0] ENTER_V = ENTER[CNT_W-1:0];
   localparam logic [CNT_W-1:0] EXIT_V  = EXIT[CNT_W-1:0];

   logic state_nx;

   if (ENTER >= EXIT) begin : g_bad_band
      $error("enter tolerance must be below exit tolerance");
   end
   if (EXIT >= (1 << CNT_W)) begin : g_bad_exit
      $error("exit tolerance does not fit CNT_W");
   end

   always_comb begin
      if (!en)       state_nx = 1'b0;
      else if (upd)  state_nx = state ? (err <= EXIT_V) : (err <= ENTER_V);
      else           state_nx = state;
   end

   assign toggle = (state_nx != state);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= 1'b0;
      else        state <= state_nx;
   end

   // R3 R5
   enter_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(state) |-> $past(err <= ENTER_V));

   // R4 R6
   exit_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(state) && $past(en)) |-> $past(err > EXIT_V));

   // R2
   hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !upd) |=> $stable(state));

   // R1
   off_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !state);

endmodule

// File: rtl/pltd_irq.sv
module pltd_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic ie,
   input  logic chg,
   input  logic clr,
   output logic irq
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= (irq & ~clr) | (ie & chg);
   end

   // R10
   irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !clr) |=> irq);

   // R10
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ie && chg) |=> irq);

   // R9
   irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(ie && chg));

endmodule

// File: rtl/pll_lock_track_det.sv
module pll_lock_track_det #(
   parameter int WIN_LEN   = 32,
   parameter int CNT_W     = 6,
   parameter int TRK_ENTER = 2,
   parameter int TRK_EXIT  = 5,
   parameter int LCK_ENTER = 1,
   parameter int LCK_EXIT  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pll_on,
   input  logic             osc_tick,
   input  logic [CNT_W-1:0] target,
   input  logic             auto_mode,
   input  logic             acq_sel,
   input  logic             lock_ie,
   input  logic             irq_clr,
   output logic             filt_acq,
   output logic             track,
   output logic             lock,
   output logic             irq,
   output logic             pll_safe
);
   import pltd_pkg::*;

   localparam int N_CMP = 2;
   localparam int IDX_TRK = 0;
   localparam int IDX_LCK = 1;

   logic             win_done;
   logic [CNT_W-1:0] win_count;
   logic [CNT_W-1:0] err;
   logic [N_CMP-1:0] cmp_state;
   logic [N_CMP-1:0] cmp_toggle;
   pltd_filt_e       filt_mode;

   pltd_window #(.WIN_LEN(WIN_LEN), .CNT_W(CNT_W)) u_window (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (pll_on),
      .tick  (osc_tick),
      .done  (win_done),
      .count (win_count)
   );

   assign err = (win_count >= target) ? (win_count - target) : (target - win_count);

   for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
      pltd_hyst #(
         .CNT_W (CNT_W),
         .ENTER ((g == IDX_TRK) ? TRK_ENTER : LCK_ENTER),
         .EXIT  ((g == IDX_TRK) ? TRK_EXIT  : LCK_EXIT)
      ) u_hyst (
         .clk    (clk),
         .rst_n  (rst_n),
         .en     (pll_on),
         .upd    (win_done),
         .err    (err),
         .state  (cmp_state[g]),
         .toggle (cmp_toggle[g])
      );
   end

   always_comb begin
      if (!rst_n || !pll_on)  filt_mode = FILT_ACQ;
      else if (auto_mode)     filt_mode = cmp_state[IDX_TRK] ? FILT_TRACK : FILT_ACQ;
      else                    filt_mode = acq_sel ? FILT_ACQ : FILT_TRACK;
   end

   assign filt_acq = (filt_mode == FILT_ACQ);
   assign track    = cmp_state[IDX_TRK] & ~filt_acq;
   assign lock     = cmp_state[IDX_LCK];
   assign pll_safe = lock;

   pltd_irq u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .ie    (lock_ie),
      .chg   (cmp_toggle[IDX_LCK]),
      .clr   (irq_clr),
      .irq   (irq)
   );

   // R7
   auto_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_mode && pll_on) |-> (filt_acq == !track));

   // R8
   manual_acq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!auto_mode && pll_on && acq_sel) |-> (filt_acq && !track));

   // R1
   off_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pll_on |-> filt_acq);

endmodule

// File: tb/pll_lock_track_det_test.sv
module pll_lock_track_det_test;
   localparam int CLK_PERIOD = 10;
   localparam int WIN  = 32;
   localparam int CW   = 6;
   localparam int NVEC = 12;

   typedef struct packed {
      logic [7:0] n;
      logic       t;
      logic       l;
      logic       i;
   } vec_t;

   // target 20; track enter<=2 exit>5; lock enter<=1 exit>3
   localparam vec_t TAB [NVEC] = '{
      '{8'd30, 1'b0, 1'b0, 1'b0},   // err 10
      '{8'd24, 1'b0, 1'b0, 1'b0},   // err 4: above track enter (R3)
      '{8'd22, 1'b1, 1'b0, 1'b0},   // err 2: track enters at bound (R3)
      '{8'd21, 1'b1, 1'b1, 1'b1},   // err 1: lock enters at bound (R5, R9)
      '{8'd23, 1'b1, 1'b1, 1'b1},   // err 3: lock holds at exit bound (R6)
      '{8'd24, 1'b1, 1'b0, 1'b1},   // err 4: lock exits, track holds (R6, R4)
      '{8'd17, 1'b1, 1'b0, 1'b1},   // err 3: lock does not re-enter (R5)
      '{8'd20, 1'b1, 1'b1, 1'b1},   // err 0
      '{8'd15, 1'b1, 1'b0, 1'b1},   // err 5: track holds at exit bound (R4)
      '{8'd14, 1'b0, 1'b0, 1'b1},   // err 6: track exits (R4)
      '{8'd19, 1'b1, 1'b1, 1'b1},   // err 1: both enter
      '{8'd26, 1'b0, 1'b0, 1'b1}    // err 6: both exit
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pll_on = 1'b0;
   logic          osc_tick = 1'b0;
   logic [CW-1:0] target = CW'(20);
   logic          auto_mode = 1'b1;
   logic          acq_sel = 1'b1;
   logic          lock_ie = 1'b1;
   logic          irq_clr = 1'b0;
   logic          filt_acq, track, lock, irq, pll_safe;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pll_lock_track_det #(.WIN_LEN(WIN), .CNT_W(CW)) uut (
      .clk(clk), .rst_n(rst_n), .pll_on(pll_on), .osc_tick(osc_tick),
      .target(target), .auto_mode(auto_mode), .acq_sel(acq_sel),
      .lock_ie(lock_ie), .irq_clr(irq_clr), .filt_acq(filt_acq),
      .track(track), .lock(lock), .irq(irq), .pll_safe(pll_safe)
   );

   task automatic check(input string tag, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic check_flags(input string tag, input logic et, input logic el, input logic ei);
      check({tag, " track"}, track, et);
      check({tag, " lock"}, lock, el);
      check({tag, " irq"}, irq, ei);
      check({"R11 ", tag, " pll_safe"}, pll_safe, el);
      if (auto_mode) check({"R7 ", tag, " filt_acq"}, filt_acq, !et);
   endtask

   // Drives one window with n ticks. If chk is set, checks the outcome of the
   // previous window right after the first edge, and again mid-window (R2).
   task automatic run_win(input int n, input bit clr0, input bit chk,
                          input string tag, input logic et, input logic el, input logic ei);
      for (int i = 0; i < WIN; i++) begin
         osc_tick = (i < n);
         irq_clr  = clr0 && (i == 0);
         @(negedge clk);
         if (chk && i == 0)       check_flags(tag, et, el, ei);
         if (chk && i == WIN / 2) check_flags({"R2 mid ", tag}, et, el, ei);
      end
      irq_clr = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 reset filt_acq", filt_acq, 1'b1);
      check("R1 reset track", track, 1'b0);
      check("R1 reset lock", lock, 1'b0);
      check("R1 reset irq", irq, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 off filt_acq", filt_acq, 1'b1);

      // Table: auto mode, interrupt enabled (R2-R7, R9)
      pll_on = 1'b1;
      for (int k = 0; k < NVEC; k++) begin
         if (k == 0) run_win(int'(TAB[k].n), 1'b0, 1'b0, "", 1'b0, 1'b0, 1'b0);
         else        run_win(int'(TAB[k].n), 1'b0, 1'b1, $sformatf("R3/R4/R5/R6 row%0d", k - 1),
                             TAB[k-1].t, TAB[k-1].l, TAB[k-1].i);
      end
      run_win(20, 1'b0, 1'b1, "R4/R6 row11", TAB[NVEC-1].t, TAB[NVEC-1].l, TAB[NVEC-1].i);
      run_win(20, 1'b0, 1'b1, "R3/R5 relock", 1'b1, 1'b1, 1'b1);

      // R1: switching off clears flags at the next edge
      pll_on = 1'b0;
      @(negedge clk);
      check("R1 pll off track", track, 1'b0);
      check("R1 pll off lock", lock, 1'b0);
      check("R1 pll off filt_acq", filt_acq, 1'b1);

      // R8 manual mode
      pll_on = 1'b1;
      auto_mode = 1'b0;
      acq_sel = 1'b1;
      run_win(20, 1'b0, 1'b0, "", 1'b0, 1'b0, 1'b0);
      run_win(20, 1'b0, 1'b1, "R8 manual acq", 1'b0, 1'b1, 1'b1);
      check("R8 manual acq filt_acq", filt_acq, 1'b1);
      acq_sel = 1'b0;
      #1;
      check("R8 manual trk filt_acq", filt_acq, 1'b0);
      check("R8 manual trk track", track, 1'b1);
      auto_mode = 1'b1;
      #1;

      // R10 plain clear, then clear coinciding with a lock change
      run_win(20, 1'b1, 1'b1, "R10 clear", 1'b1, 1'b1, 1'b0);
      run_win(30, 1'b0, 1'b1, "R10 stay clear", 1'b1, 1'b1, 1'b0);
      run_win(20, 1'b1, 1'b1, "R10 set wins", 1'b0, 1'b0, 1'b1);

      // R9 interrupt disabled: lock changes leave irq alone
      lock_ie = 1'b0;
      run_win(30, 1'b1, 1'b1, "R9 ie off rise", 1'b1, 1'b1, 1'b0);
      run_win(20, 1'b0, 1'b1, "R9 ie off fall", 1'b0, 1'b0, 1'b0);
      run_win(20, 1'b0, 1'b1, "R9 ie off rise2", 1'b1, 1'b1, 1'b0);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=running expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule